// File: doc/BRIEF.md
# SPI Command Word Receiver

This block is the device-side end of a four-wire serial link driven by a host controller. Each time chip select is held low, the host clocks one 16-bit word in, most significant bit first. The serial clock idles low and runs at roughly 4 MHz. Data is stable at each rising edge and changes on each falling edge. The block brings the serial pins into the system clock domain through two-flop synchronisers. It finds SCK rising edges in that domain and shifts the bits into a word register. Once the sixteenth bit has arrived, it splits the word into a 4-bit command and a 12-bit operand.

Every complete word produces a one-cycle command strobe, and the decoded fields stay on the outputs until the next complete word. The set-mode command (code 1) writes the low eight operand bits into a persistent mode register, which selects the device's operating mode. The output side is a plain strobe with no ready input. The serial host cannot be stalled, so there is no back-pressure, and any consumer must take each strobe on the cycle it occurs.

Top module: `spi_cmd_rx`

## Requirements
- R1: While reset is held and just after it, mode_reg, cmd_code and cmd_data are zero and cmd_strobe is low.
- R2: A frame consists of the first 16 bits sampled on SCK rising edges while chip select is low, taken MSB first. The first 4 bits become cmd_code and the last 12 become cmd_data.
- R3: cmd_strobe is high for exactly one system clock cycle per complete frame.
- R4: If chip select returns high before the 16th bit, the partial frame is discarded: no strobe, and outputs and mode unchanged. The next selection starts a fresh frame.
- R5: Bits clocked after the 16th within the same chip select window are ignored.
- R6: A complete frame with command code 4'h1 loads cmd_data[7:0] into mode_reg.
- R7: A complete frame with any other command code leaves mode_reg unchanged.
- R8: cmd_code, cmd_data and mode_reg hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host, idles low |
| spi_mosi | input | 1 | Serial data from host |
| spi_cs_n | input | 1 | Active-low chip select |
| mode_reg | output | 8 | Persistent operating-mode register |
| cmd_strobe | output | 1 | One-cycle pulse when a complete frame is decoded |
| cmd_code | output | 4 | Command field of the last complete frame |
| cmd_data | output | 12 | Operand field of the last complete frame |

## Verification
The hardest situations to reach from the ports are selections whose bit count is not sixteen. One case is a frame cut short by chip select, which must leave every output untouched and must not corrupt the next frame. The other is an over-long selection, whose trailing bits must not shift into the word already decoded. The bench's serial driver takes a bit count per vector. The table therefore places a ten-bit burst between full frames and a twenty-bit burst with trailing ones. It also places set-mode frames before and after these bursts, so that a stale or shifted word would appear in mode_reg.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int unsigned FRAME_W = 16;
  localparam int unsigned CMD_W   = 4;
  localparam int unsigned MODE_W  = 8;
  localparam logic [CMD_W-1:0] CMD_SET_MODE = 4'h1;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_cmd_deframer.sv
module spi_cmd_deframer #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck_s,
  input  logic               mosi_s,
  input  logic               cs_n_s,
  output logic [FRAME_W-1:0] frame_word,
  output logic               frame_done
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic             sck_prev;
  logic             sck_rise;
  logic [CNT_W-1:0] bit_cnt;

  assign sck_rise = sck_s & ~sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev   <= 1'b0;
      bit_cnt    <= '0;
      frame_word <= '0;
      frame_done <= 1'b0;
    end else begin
      sck_prev   <= sck_s;
      frame_done <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
      end else if (sck_rise && bit_cnt < FULL) begin
        frame_word <= {frame_word[FRAME_W-2:0], mosi_s};
        bit_cnt    <= bit_cnt + 1'b1;
        frame_done <= (bit_cnt == LAST);
      end
    end
  end

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= FULL);
  a_r4_cs_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (bit_cnt == '0) && !frame_done);
  a_r5_no_shift_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == FULL) |=> $stable(frame_word));
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned CMD_W   = 4,
  parameter int unsigned MODE_W  = 8,
  parameter logic [CMD_W-1:0] SET_CODE = 4'h1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [FRAME_W-1:0]         frame_word,
  input  logic                       frame_done,
  output logic [MODE_W-1:0]          mode_reg,
  output logic                       cmd_strobe,
  output logic [CMD_W-1:0]           cmd_code,
  output logic [FRAME_W-CMD_W-1:0]   cmd_data
);
  localparam int unsigned DATA_W = FRAME_W - CMD_W;

  logic [CMD_W-1:0]  code_in;
  logic [DATA_W-1:0] data_in;

  assign code_in = frame_word[FRAME_W-1 -: CMD_W];
  assign data_in = frame_word[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_reg   <= '0;
      cmd_strobe <= 1'b0;
      cmd_code   <= '0;
      cmd_data   <= '0;
    end else begin
      cmd_strobe <= frame_done;
      if (frame_done) begin
        cmd_code <= code_in;
        cmd_data <= data_in;
        if (code_in == SET_CODE) mode_reg <= data_in[MODE_W-1:0];
      end
    end
  end

  a_r3_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |=> !cmd_strobe);
  a_r8_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_strobe |-> $stable(cmd_code) && $stable(cmd_data));
  a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_strobe || cmd_code != SET_CODE) |-> $stable(mode_reg));
  a_r6_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe && cmd_code == SET_CODE) |-> mode_reg == cmd_data[MODE_W-1:0]);
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spi_cmd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        spi_sck,
  input  logic                        spi_mosi,
  input  logic                        spi_cs_n,
  output logic [MODE_W-1:0]           mode_reg,
  output logic                        cmd_strobe,
  output logic [CMD_W-1:0]            cmd_code,
  output logic [FRAME_W-CMD_W-1:0]    cmd_data
);
  logic [2:0]         pins_s;
  logic [FRAME_W-1:0] frame_word;
  logic               frame_done;

  spi_cmd_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({spi_cs_n, spi_mosi, spi_sck}),
    .dout  (pins_s)
  );

  spi_cmd_deframer #(
    .FRAME_W (FRAME_W)
  ) u_deframe (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_s      (pins_s[0]),
    .mosi_s     (pins_s[1]),
    .cs_n_s     (pins_s[2]),
    .frame_word (frame_word),
    .frame_done (frame_done)
  );

  spi_cmd_decode #(
    .FRAME_W  (FRAME_W),
    .CMD_W    (CMD_W),
    .MODE_W   (MODE_W),
    .SET_CODE (CMD_SET_MODE)
  ) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_word (frame_word),
    .frame_done (frame_done),
    .mode_reg   (mode_reg),
    .cmd_strobe (cmd_strobe),
    .cmd_code   (cmd_code),
    .cmd_data   (cmd_data)
  );
endmodule

// File: tb/spi_cmd_rx_tb.sv
module spi_cmd_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 8;
  localparam int NV         = 8;

  localparam logic [15:0] T_WORD [NV] = '{16'h10A5, 16'h23C7, 16'h1F3C, 16'h1077,
                                          16'hFFFF, 16'h1000, 16'h1181, 16'h00FF};
  localparam int          T_BITS [NV] = '{16, 16, 16, 10, 16, 16, 20, 16};
  localparam logic [7:0]  T_MODE [NV] = '{8'hA5, 8'hA5, 8'h3C, 8'h3C,
                                          8'h3C, 8'h00, 8'h81, 8'h81};
  localparam logic        T_STRB [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sck = 1'b0;
  logic        spi_mosi = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic [7:0]  mode_reg;
  logic        cmd_strobe;
  logic [3:0]  cmd_code;
  logic [11:0] cmd_data;

  int n_checks = 0;
  int n_fail   = 0;
  int strobe_cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (cmd_strobe) strobe_cycles++;

  spi_cmd_rx u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_sck    (spi_sck),
    .spi_mosi   (spi_mosi),
    .spi_cs_n   (spi_cs_n),
    .mode_reg   (mode_reg),
    .cmd_strobe (cmd_strobe),
    .cmd_code   (cmd_code),
    .cmd_data   (cmd_data)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int nbits);
    spi_cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = (i < 16) ? w[15-i] : 1'b1;
      wait_clk(HALF_SCK);
      spi_sck = 1'b1;
      wait_clk(HALF_SCK);
      spi_sck = 1'b0;
    end
    wait_clk(4);
    spi_cs_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [3:0]  exp_code;
    logic [11:0] exp_data;
    int          sc_before;

    wait_clk(3);
    check("R1", "mode in reset", int'(mode_reg), 0);
    check("R1", "strobe in reset", int'(cmd_strobe), 0);
    rst_n = 1'b1;
    wait_clk(3);
    check("R1", "code after reset", int'(cmd_code), 0);
    check("R1", "data after reset", int'(cmd_data), 0);
    check("R1", "mode after reset", int'(mode_reg), 0);

    exp_code = '0;
    exp_data = '0;
    for (int v = 0; v < NV; v++) begin
      sc_before = strobe_cycles;
      send(T_WORD[v], T_BITS[v]);
      if (T_STRB[v]) begin
        exp_code = T_WORD[v][15:12];
        exp_data = T_WORD[v][11:0];
      end
      if (!T_STRB[v]) begin
        check("R4", "partial strobe count", strobe_cycles - sc_before, 0);
        check("R8", "code held", int'(cmd_code), int'(exp_code));
        check("R8", "data held", int'(cmd_data), int'(exp_data));
        check("R4", "mode after partial", int'(mode_reg), int'(T_MODE[v]));
      end else begin
        check("R3", "strobe cycles", strobe_cycles - sc_before, 1);
        if (T_BITS[v] > 16) begin
          check("R5", "code with trailing bits", int'(cmd_code), int'(exp_code));
          check("R5", "data with trailing bits", int'(cmd_data), int'(exp_data));
        end else begin
          check("R2", "code", int'(cmd_code), int'(exp_code));
          check("R2", "data", int'(cmd_data), int'(exp_data));
        end
        if (exp_code == 4'h1) check("R6", "mode load", int'(mode_reg), int'(T_MODE[v]));
        else                  check("R7", "mode unchanged", int'(mode_reg), int'(T_MODE[v]));
      end
    end

    // Chip select pulse with no clocks: nothing happens
    sc_before = strobe_cycles;
    spi_cs_n = 1'b0;
    wait_clk(20);
    spi_cs_n = 1'b1;
    wait_clk(10);
    check("R4", "empty select strobe", strobe_cycles - sc_before, 0);
    check("R8", "empty select mode", int'(mode_reg), 8'h81);

    // Short burst then full frame: counter restarted
    send(16'hFFFF, 5);
    sc_before = strobe_cycles;
    send(16'h10C3, 16);
    check("R4", "fresh frame after abort", int'(cmd_data), 12'h0C3);
    check("R6", "mode after abort and frame", int'(mode_reg), 8'hC3);
    check("R3", "single strobe", strobe_cycles - sc_before, 1);

    // Reset in operation
    rst_n = 1'b0;
    wait_clk(2);
    check("R1", "mode cleared by reset", int'(mode_reg), 0);
    check("R1", "code cleared by reset", int'(cmd_code), 0);
    rst_n = 1'b1;
    wait_clk(3);
    send(16'h1055, 16);
    check("R6", "mode after re-reset", int'(mode_reg), 8'h55);

    finished = 1'b1;
    summary();
  end
endmodule